// File: doc/BRIEF.md
# Self-Synchronizing Pattern Checker with Link Status

This block sits behind a deserializer and checks each received W-bit word against a locally produced copy of a test pattern. The pattern can be one of four pseudo-random sequences or one of two clock-like square waves. The receive pattern select is a block input of its own, so it does not depend on the transmit side. While the link is down, the checker takes its reference history from the received bits, so it locks to an incoming sequence without a seed exchange. Once the link is up, the reference runs on by itself, and a bit error on the line spoils only the word that carries it.

Two saturating counters record the received words and the errored words. A link flag drops after a run of consecutive errored words. It rises again after a run of clean words. Clock recovery and word alignment are done upstream.

Top module: `prbs_rx_checker`

## Requirements
- R1: While `rst` is high, and after it is released with no further input, `link_up` is 0 and both counters read 0.
- R2: `pat_sel` encodes the expected stream, and bit 0 of each word is the earliest bit in time. The codes are:
  - 0: b[k]=b[k-7]^b[k-6]
  - 1: b[k]=b[k-15]^b[k-14]
  - 2: b[k]=b[k-23]^b[k-18]
  - 3: b[k]=b[k-31]^b[k-28]
  - 4: alternating bits, b[k]=~b[k-1]
  - 5: ten ones then ten zeros, b[k]=~b[k-10]

  The checker locks to a clean stream of each of these.
- R3: `word_cnt` increases by one for each clock with `valid_in` high. Cycles with `valid_in` low change neither counter.
- R4: `err_cnt` increases by one for each valid word in which at least one bit differs from the reference. This applies whether the link is up or down.
- R5: With the link up, `link_up` falls after the fifth consecutive errored valid word. A clean valid word restarts the run. Invalid cycles neither extend the run nor restart it.
- R6: With the link down, `link_up` rises after 16 consecutive clean valid words.
- R7: While the link is down, the reference history is loaded from the received bits. While it is up, the reference advances from its own prediction, so a single flipped bit adds exactly one to `err_cnt`.
- R8: Any change of `pat_sel` forces `link_up` low on the next clock and restarts locking.
- R9: `cnt_clr` zeroes both counters on the next clock, and it takes priority over counting.
- R10: Both counters (width `CNT_W`, default 48) stop at all ones and do not wrap.
- R11: Every output updates on the clock edge that samples the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Received word is valid this cycle |
| data_in | input | W | Received word, bit 0 earliest |
| pat_sel | input | 3 | Expected pattern code |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| link_up | output | 1 | Link status flag |
| word_cnt | output | CNT_W | Valid words received |
| err_cnt | output | CNT_W | Valid words with at least one bit error |

## Verification
A clean stream of all six pattern codes shows that each recurrence locks, which separates the taps of each code. Single-bit flips with the link up show that the reference free-runs rather than following the errors, because each flip must cost exactly one errored word. Runs of four errored words with idle gaps set against a run of five separate the loss threshold from gap handling. Random words held long enough to saturate the narrowed counters, a mid-lock select change, and a clear that arrives together with a valid word cover the remaining corner cases.

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker #(
  parameter int W        = 16,
  parameter int CNT_W    = 48,
  parameter int LOSS_RUN = 5,
  parameter int LOCK_RUN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [W-1:0]     data_in,
  input  logic [2:0]       pat_sel,
  input  logic             cnt_clr,
  output logic             link_up,
  output logic [CNT_W-1:0] word_cnt,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int HW = 31;
  localparam int EW = $clog2(LOSS_RUN + 1);
  localparam int GW = $clog2(LOCK_RUN + 1);

  logic [HW-1:0]   hist;
  logic [2:0]      sel_q;
  logic [EW-1:0]   err_run;
  logic [GW-1:0]   good_run;
  logic [W-1:0]    expect_w;
  logic [W-1:0]    shift_src;
  logic [HW+W-1:0] joined;
  logic            sel_chg, bad_word;

  function automatic logic [W-1:0] predict(input logic [HW-1:0] h, input logic [2:0] s);
    logic [HW+W-1:0] q;
    q = '0;
    q[HW-1:0] = h;
    for (int i = 0; i < W; i++) begin
      case (s)
        3'd1:    q[HW+i] = q[HW+i-15] ^ q[HW+i-14];
        3'd2:    q[HW+i] = q[HW+i-23] ^ q[HW+i-18];
        3'd3:    q[HW+i] = q[HW+i-31] ^ q[HW+i-28];
        3'd4:    q[HW+i] = ~q[HW+i-1];
        3'd5:    q[HW+i] = ~q[HW+i-10];
        default: q[HW+i] = q[HW+i-7] ^ q[HW+i-6];
      endcase
    end
    return q[HW+W-1:HW];
  endfunction

  assign expect_w  = predict(hist, pat_sel);
  assign sel_chg   = pat_sel != sel_q;
  assign bad_word  = valid_in && (data_in != expect_w);
  assign shift_src = (link_up && !sel_chg) ? expect_w : data_in;
  assign joined    = {shift_src, hist};

  always_ff @(posedge clk) begin
    sel_q <= pat_sel;
    if (rst) begin
      hist     <= '0;
      link_up  <= 1'b0;
      err_run  <= '0;
      good_run <= '0;
    end else begin
      if (valid_in) hist <= joined[HW+W-1:W];
      if (sel_chg) begin
        link_up  <= 1'b0;
        err_run  <= '0;
        good_run <= '0;
      end else if (valid_in) begin
        if (bad_word) begin
          good_run <= '0;
          if (err_run != EW'(LOSS_RUN)) err_run <= err_run + EW'(1);
          if (link_up && err_run == EW'(LOSS_RUN - 1)) link_up <= 1'b0;
        end else begin
          err_run <= '0;
          if (good_run != GW'(LOCK_RUN)) good_run <= good_run + GW'(1);
          if (!link_up && good_run == GW'(LOCK_RUN - 1)) link_up <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      word_cnt <= '0;
      err_cnt  <= '0;
    end else begin
      if (valid_in && word_cnt != '1) word_cnt <= word_cnt + CNT_W'(1);
      if (bad_word && err_cnt != '1)  err_cnt  <= err_cnt + CNT_W'(1);
    end
  end
endmodule

module prbs_rx_checker_sva #(
  parameter int W     = 16,
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_in,
  input logic [2:0]       pat_sel,
  input logic             cnt_clr,
  input logic             link_up,
  input logic [CNT_W-1:0] word_cnt,
  input logic [CNT_W-1:0] err_cnt
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!link_up && word_cnt == '0 && err_cnt == '0));

  a_r3_idle_words: assert property (@(posedge clk) disable iff (rst)
    (!valid_in && !cnt_clr) |=> $stable(word_cnt));

  a_r4_idle_errors: assert property (@(posedge clk) disable iff (rst)
    (!valid_in && !cnt_clr) |=> $stable(err_cnt));

  a_r5_no_drop_idle: assert property (@(posedge clk) disable iff (rst)
    (!valid_in && pat_sel == $past(pat_sel)) |=> !$fell(link_up));

  a_r6_no_rise_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !$rose(link_up));

  a_r8_select_drop: assert property (@(posedge clk) disable iff (rst)
    (pat_sel != $past(pat_sel)) |=> !link_up);

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (word_cnt == '0 && err_cnt == '0));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (word_cnt == '1 && !cnt_clr) |=> word_cnt == '1);
endmodule

bind prbs_rx_checker prbs_rx_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst(rst), .valid_in(valid_in), .pat_sel(pat_sel), .cnt_clr(cnt_clr),
  .link_up(link_up), .word_cnt(word_cnt), .err_cnt(err_cnt)
);

// File: tb/prbs_rx_checker_tb.sv
module prbs_rx_checker_tb;
  localparam int W = 16;
  localparam int CW = 8;
  localparam logic [CW-1:0] TOP = '1;

  logic clk = 1'b0, rst = 1'b1, valid_in = 1'b0, cnt_clr = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [2:0] pat_sel = 3'd0;
  logic link_up;
  logic [CW-1:0] word_cnt, err_cnt;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  prbs_rx_checker #(.W(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .data_in(data_in), .pat_sel(pat_sel),
    .cnt_clr(cnt_clr), .link_up(link_up), .word_cnt(word_cnt), .err_cnt(err_cnt)
  );

  typedef struct { logic lk; logic [CW-1:0] wc; logic [CW-1:0] ec; string tag; } exp_t;
  exp_t sb[$];

  // reference model state, built from the requirement text
  logic [30:0] m_hist = '0;
  logic m_link = 1'b0;
  int m_er = 0, m_gr = 0;
  logic [CW-1:0] m_wc = '0, m_ec = '0;
  logic [2:0] m_sel = 3'd0;

  // stimulus generator state
  logic [30:0] g_hist = '1;
  logic g_tog = 1'b0;
  int g_ph = 0;

  function automatic logic [W-1:0] ref_word(input logic [30:0] h, input logic [2:0] s);
    logic b [0:30+W];
    logic [W-1:0] r;
    int a, c;
    for (int t = 0; t < 31; t++) b[t] = h[t];
    for (int i = 0; i < W; i++) begin
      int k = 31 + i;
      case (s)
        3'd1: begin a = 15; c = 14; end
        3'd2: begin a = 23; c = 18; end
        3'd3: begin a = 31; c = 28; end
        default: begin a = 7; c = 6; end
      endcase
      if (s == 3'd4) b[k] = !b[k-1];
      else if (s == 3'd5) b[k] = !b[k-10];
      else b[k] = b[k-a] ^ b[k-c];
      r[i] = b[k];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] gen_word(input logic [2:0] s);
    logic [W-1:0] r;
    if (s == 3'd4) begin
      for (int i = 0; i < W; i++) begin r[i] = g_tog; g_tog = !g_tog; end
    end else if (s == 3'd5) begin
      for (int i = 0; i < W; i++) begin r[i] = (g_ph < 10); g_ph = (g_ph + 1) % 20; end
    end else begin
      r = ref_word(g_hist, s);
      g_hist = {r, g_hist} >> W;
    end
    return r;
  endfunction

  task automatic step(input logic v, input logic [W-1:0] d, input logic [2:0] s,
                      input logic c, input string tag);
    logic chg, bad;
    logic [W-1:0] e;
    exp_t it;
    @(negedge clk);
    valid_in = v; data_in = d; pat_sel = s; cnt_clr = c;
    chg = (s != m_sel);
    m_sel = s;
    e = ref_word(m_hist, s);
    bad = v && (d != e);
    if (v) m_hist = {((m_link && !chg) ? e : d), m_hist} >> W;
    if (chg) begin m_link = 1'b0; m_er = 0; m_gr = 0; end
    else if (v) begin
      if (bad) begin
        m_gr = 0;
        if (m_link && m_er == 4) m_link = 1'b0;
        if (m_er < 5) m_er++;
      end else begin
        m_er = 0;
        if (!m_link && m_gr == 15) m_link = 1'b1;
        if (m_gr < 16) m_gr++;
      end
    end
    if (c) begin m_wc = '0; m_ec = '0; end
    else begin
      if (v && m_wc != TOP) m_wc++;
      if (bad && m_ec != TOP) m_ec++;
    end
    it.lk = m_link; it.wc = m_wc; it.ec = m_ec; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, pat_sel, 1'b0, "R3");
  endtask

  task automatic clean(input int n, input logic [2:0] s, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, gen_word(s), s, 1'b0, tag);
  endtask

  task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: sample mid-high phase after the edge that took each driven word
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (link_up !== it.lk || word_cnt !== it.wc || err_cnt !== it.ec) begin
        errors++;
        $display("FAIL %s (R11): actual link=%0b words=%0d errs=%0d expected link=%0b words=%0d errs=%0d",
                 it.tag, link_up, word_cnt, err_cnt, it.lk, it.wc, it.ec);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] e0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(link_up, 0, "R1"); chk(word_cnt, 0, "R1"); chk(err_cnt, 0, "R1");

    clean(40, 3'd0, "R6");
    idle(1);
    chk(link_up, 1, "R6");

    e0 = err_cnt;
    step(1'b1, gen_word(3'd0) ^ 16'h0100, 3'd0, 1'b0, "R7");
    clean(3, 3'd0, "R7");
    idle(1);
    chk(err_cnt, e0 + 1, "R7"); chk(link_up, 1, "R7");

    for (int i = 0; i < 4; i++) begin
      step(1'b1, gen_word(3'd0) ^ 16'h0001, 3'd0, 1'b0, "R5");
      idle(1);
    end
    clean(2, 3'd0, "R5");
    idle(1);
    chk(link_up, 1, "R5");

    for (int i = 0; i < 4; i++) step(1'b1, gen_word(3'd0) ^ 16'h8000, 3'd0, 1'b0, "R5");
    idle(3);
    step(1'b1, gen_word(3'd0) ^ 16'h8000, 3'd0, 1'b0, "R5");
    idle(1);
    chk(link_up, 0, "R5");

    clean(20, 3'd0, "R6");
    idle(1);
    chk(link_up, 1, "R6");

    for (int s = 1; s < 6; s++) begin
      g_hist = '1; g_tog = 1'b0; g_ph = 3;
      step(1'b1, gen_word(3'(s)), 3'(s), 1'b0, "R8");
      idle(1);
      chk(link_up, 0, "R8");
      clean(40, 3'(s), "R2");
      idle(1);
      chk(link_up, 1, "R2");
    end

    step(1'b1, gen_word(3'd5), 3'd5, 1'b1, "R9");
    idle(1);
    chk(word_cnt, 0, "R9"); chk(err_cnt, 0, "R9");

    for (int i = 0; i < 280; i++) step(1'b1, W'($urandom), 3'd3, 1'b0, "R10");
    idle(2);
    chk(word_cnt, TOP, "R10");
    chk(err_cnt, m_ec, "R4");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule